// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block is the command front end of an on-chip flash controller. Software issues commands as bus writes. Only the low byte of each write carries the command code. The high byte goes through unchanged as program data and plays no part in decoding. A command takes one or two writes:

- A one-write command acts at once.
- A two-write command first latches a pending operation and a target block. The second write then either confirms it or cancels it.
- For a program command, the second write is the data word itself.

When a command is confirmed, the block checks the target block against an eight-entry lock store. It then either reports an error or starts an automatic operation on the array. The array is represented by a stub that answers with done, fail and blank-result inputs.

Results are reported in a two-bit error field:

| Code | Meaning |
|------|---------|
| 11 | command-sequence error |
| 10 | erase-class failure |
| 01 | program-class failure |

The error field is sticky until a clear-status command is written. While an error is present, any command that would start an automatic operation is refused. A lock-override input suppresses every error that comes from a locked block.

Command codes, taken from the low byte of the write:

| Code | Command |
|------|---------|
| 40h | program |
| 20h | block erase |
| 25h | blank check |
| 77h | lock-bit program |
| 71h | read lock status |
| 50h | clear status |
| FFh | no-op |

On the second write, D0h confirms and FFh cancels. Lock store encoding: 1 means unlocked and 0 means locked.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, ready_o=1, err_o=00, arr_start_o=0, lock_bit_o=1, and every block's lock bit is 1 (unlocked).
- R2: err_o encodes 11 = sequence error, 10 = erase error, 01 = program error, 00 = none. A nonzero value stays until a clear-status write (50h) in the idle state returns it to 00. A later error replaces it.
- R3: In the idle state, a first write whose low byte is not one of the seven command codes sets err_o=11 and starts nothing.
- R4: For erase, blank check, lock-bit program and read lock status, a second write whose low byte is neither D0h nor FFh sets err_o=11, starts nothing and returns to idle.
- R5: A second write with low byte FFh for those four commands cancels the pending command. err_o is unchanged, nothing starts, and the next write is decoded as a new first write.
- R6: A confirmed block erase of a locked block, with lock_dis_i=0, sets err_o=10 without a start. On an unlocked block it starts an erase, and arr_fail_i at done sets err_o=10.
- R7: A confirmed blank check always starts. arr_blank_i=0 at done sets err_o=10, and arr_blank_i=1 leaves err_o=00.
- R8: A program of a locked block, with lock_dis_i=0, sets err_o=01 without a start. A program or lock-bit program whose done arrives with arr_fail_i=1 sets err_o=01. A successful lock-bit program clears that block's lock bit to 0.
- R9: With lock_dis_i=1, a locked block gives no error, and erase or program starts as on an unlocked block.
- R10: arr_start_o pulses for one cycle on the cycle after the confirming write. ready_o is 0 from that cycle until the cycle after arr_done_i. Writes while ready_o=0 are ignored.
- R11: While err_o is nonzero, a first write of 40h, 20h, 25h or 77h sets err_o=11 and starts nothing.
- R12: A confirmed read lock status drives lock_bit_o with the addressed block's lock bit (1 unlocked, 0 locked) on the cycle after the confirm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | DATA_W | Write data; the low byte is the command code |
| wr_blk_i | input | BLK_W | Target block, taken on the first write |
| lock_dis_i | input | 1 | 1 overrides block locks |
| arr_done_i | input | 1 | Array operation finished |
| arr_fail_i | input | 1 | Array operation failed (valid with done) |
| arr_blank_i | input | 1 | Blank-check result, 1 = blank (valid with done) |
| ready_o | output | 1 | 1 = ready, 0 = busy |
| err_o | output | 2 | Error status code |
| lock_bit_o | output | 1 | Result of the last read lock status |
| arr_start_o | output | 1 | One-cycle start pulse to the array |
| arr_op_o | output | 2 | Operation: 0 erase, 1 program, 2 blank, 3 lock-bit |
| arr_blk_o | output | BLK_W | Target block to the array |
| arr_data_o | output | DATA_W | Program data to the array |

## Verification
The checker watches the following on every cycle:
- The busy window: start implies busy, busy holds until done, and done returns to ready.
- The stickiness of the error field.
- The refusal of new operations while an error is present.
- The handling of an unknown command code, a bad confirm and a cancelling confirm.

Only the bench scenarios can show that each error code follows from the right combination of lock state, lock override and array result. The same is true of a lock-bit program changing what a later read lock status or erase sees, and of a write during busy leaving the status untouched.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_PROG, CMD_ERASE, CMD_BLANK,
    CMD_LOCKPROG, CMD_RDLOCK, CMD_CLRSTAT, CMD_BAD
  } cmd_e;

  typedef enum logic [1:0] {ST_IDLE, ST_CONF, ST_BUSY} state_e;

  typedef enum logic [1:0] {OP_ERASE = 2'd0, OP_PROG = 2'd1, OP_BLANK = 2'd2, OP_LOCK = 2'd3} op_e;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_SEQ   = 2'b11;
  localparam logic [1:0] ERR_ERASE = 2'b10;
  localparam logic [1:0] ERR_PROG  = 2'b01;

  localparam logic [7:0] CODE_PROG    = 8'h40;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_BLANK   = 8'h25;
  localparam logic [7:0] CODE_LOCKPRG = 8'h77;
  localparam logic [7:0] CODE_RDLOCK  = 8'h71;
  localparam logic [7:0] CODE_CLRSTAT = 8'h50;
  localparam logic [7:0] CODE_NOP     = 8'hFF;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_CANCEL  = 8'hFF;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o,
  output logic       auto_o
);
  always_comb begin
    case (code_i)
      CODE_PROG:    cmd_o = CMD_PROG;
      CODE_ERASE:   cmd_o = CMD_ERASE;
      CODE_BLANK:   cmd_o = CMD_BLANK;
      CODE_LOCKPRG: cmd_o = CMD_LOCKPROG;
      CODE_RDLOCK:  cmd_o = CMD_RDLOCK;
      CODE_CLRSTAT: cmd_o = CMD_CLRSTAT;
      CODE_NOP:     cmd_o = CMD_NONE;
      default:      cmd_o = CMD_BAD;
    endcase
    auto_o = cmd_o inside {CMD_PROG, CMD_ERASE, CMD_BLANK, CMD_LOCKPROG};
  end
endmodule

// File: rtl/fcs_lock_store.sv
module fcs_lock_store #(
  parameter int NBLK  = 8,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic [BLK_W-1:0] idx_i,
  output logic             unl_o
);
  logic [NBLK-1:0] unl;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic unl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              unl_q <= 1'b1;
      else if (lock_i && idx_i == BLK_W'(i))    unl_q <= 1'b0;
    end
    assign unl[i] = unl_q;
  end

  assign unl_o = unl[idx_i];
endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import fcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic [1:0] code_i,
  input  logic       clr_i,
  output logic [1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= ERR_NONE;
    else if (set_i)  err_o <= code_i;
    else if (clr_i)  err_o <= ERR_NONE;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NBLK   = 8,
  parameter int BLK_W  = $clog2(NBLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BLK_W-1:0]  wr_blk_i,
  input  logic              lock_dis_i,
  input  logic              arr_done_i,
  input  logic              arr_fail_i,
  input  logic              arr_blank_i,
  output logic              ready_o,
  output logic [1:0]        err_o,
  output logic              lock_bit_o,
  output logic              arr_start_o,
  output logic [1:0]        arr_op_o,
  output logic [BLK_W-1:0]  arr_blk_o,
  output logic [DATA_W-1:0] arr_data_o
);
  state_e            st_q, st_d;
  cmd_e              pend_q, pend_d, dec_cmd;
  op_e               op_q, op_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              start_q, start_d, rdlock_q, rdlock_d;
  logic              dec_auto, unl, locked;
  logic              err_set, err_clr, lock_set;
  logic [1:0]        err_code;
  logic [7:0]        code;

  assign code   = wr_data_i[7:0];
  assign locked = !unl && !lock_dis_i;

  fcs_decode u_dec (.code_i(code), .cmd_o(dec_cmd), .auto_o(dec_auto));

  fcs_lock_store #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_set), .idx_i(blk_q), .unl_o(unl)
  );

  fcs_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(err_set), .code_i(err_code),
    .clr_i(err_clr), .err_o(err_o)
  );

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    op_d     = op_q;
    blk_d    = blk_q;
    data_d   = data_q;
    rdlock_d = rdlock_q;
    start_d  = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    err_code = ERR_NONE;
    lock_set = 1'b0;
    case (st_q)
      ST_IDLE: if (wr_en_i) begin
        case (dec_cmd)
          CMD_NONE:    ;
          CMD_CLRSTAT: err_clr = 1'b1;
          CMD_BAD:     begin err_set = 1'b1; err_code = ERR_SEQ; end
          default: begin
            if (dec_auto && err_o != ERR_NONE) begin
              err_set  = 1'b1;
              err_code = ERR_SEQ;
            end else begin
              pend_d = dec_cmd;
              blk_d  = wr_blk_i;
              st_d   = ST_CONF;
            end
          end
        endcase
      end
      ST_CONF: if (wr_en_i) begin
        st_d = ST_IDLE;
        if (pend_q == CMD_PROG) begin
          // second write is the data word, no confirm check
          if (locked) begin
            err_set = 1'b1; err_code = ERR_PROG;
          end else begin
            start_d = 1'b1; op_d = OP_PROG; data_d = wr_data_i; st_d = ST_BUSY;
          end
        end else if (code == CODE_CANCEL) begin
          st_d = ST_IDLE;
        end else if (code != CODE_CONFIRM) begin
          err_set = 1'b1; err_code = ERR_SEQ;
        end else begin
          case (pend_q)
            CMD_ERASE:
              if (locked) begin
                err_set = 1'b1; err_code = ERR_ERASE;
              end else begin
                start_d = 1'b1; op_d = OP_ERASE; st_d = ST_BUSY;
              end
            CMD_BLANK:    begin start_d = 1'b1; op_d = OP_BLANK; st_d = ST_BUSY; end
            CMD_LOCKPROG: begin start_d = 1'b1; op_d = OP_LOCK;  st_d = ST_BUSY; end
            CMD_RDLOCK:   rdlock_d = unl;
            default:      ;
          endcase
        end
      end
      ST_BUSY: if (arr_done_i) begin
        st_d = ST_IDLE;
        case (op_q)
          OP_ERASE: if (arr_fail_i)   begin err_set = 1'b1; err_code = ERR_ERASE; end
          OP_PROG:  if (arr_fail_i)   begin err_set = 1'b1; err_code = ERR_PROG;  end
          OP_BLANK: if (!arr_blank_i) begin err_set = 1'b1; err_code = ERR_ERASE; end
          OP_LOCK:
            if (arr_fail_i) begin err_set = 1'b1; err_code = ERR_PROG; end
            else            lock_set = 1'b1;
          default: ;
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pend_q   <= CMD_NONE;
      op_q     <= OP_ERASE;
      blk_q    <= '0;
      data_q   <= '0;
      start_q  <= 1'b0;
      rdlock_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      op_q     <= op_d;
      blk_q    <= blk_d;
      data_q   <= data_d;
      start_q  <= start_d;
      rdlock_q <= rdlock_d;
    end
  end

  assign ready_o     = st_q != ST_BUSY;
  assign lock_bit_o  = rdlock_q;
  assign arr_start_o = start_q;
  assign arr_op_o    = op_q;
  assign arr_blk_o   = blk_q;
  assign arr_data_o  = data_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] code_i,
  input logic       arr_done_i,
  input logic       ready_o,
  input logic [1:0] err_o,
  input logic       arr_start_o,
  input state_e     st_q,
  input cmd_e       pend_q
);
  logic idle_wr, conf_wr, auto_code, known_code;
  assign idle_wr    = wr_en_i && st_q == ST_IDLE;
  assign conf_wr    = wr_en_i && st_q == ST_CONF && pend_q != CMD_PROG;
  assign auto_code  = code_i inside {CODE_PROG, CODE_ERASE, CODE_BLANK, CODE_LOCKPRG};
  assign known_code = auto_code || code_i inside {CODE_RDLOCK, CODE_CLRSTAT, CODE_NOP};

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> !ready_o);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !arr_done_i) |=> (!ready_o && $stable(err_o)));
  p_done_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && arr_done_i) |=> ready_o);
  p_err_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != ERR_NONE && !(idle_wr && code_i == CODE_CLRSTAT)) |=> err_o != ERR_NONE);
  p_unknown_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_wr && !known_code) |=> (err_o == ERR_SEQ && st_q == ST_IDLE && !arr_start_o));
  p_bad_confirm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_wr && code_i != CODE_CONFIRM && code_i != CODE_CANCEL)
      |=> (err_o == ERR_SEQ && ready_o && !arr_start_o));
  p_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_wr && code_i == CODE_CANCEL)
      |=> (err_o == $past(err_o) && st_q == ST_IDLE && !arr_start_o));
  p_reject_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_wr && auto_code && err_o != ERR_NONE)
      |=> (err_o == ERR_SEQ && st_q == ST_IDLE && !arr_start_o));
endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .code_i(wr_data_i[7:0]),
  .arr_done_i(arr_done_i), .ready_o(ready_o), .err_o(err_o),
  .arr_start_o(arr_start_o), .st_q(st_q), .pend_q(pend_q)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int DATA_W = 16;
  localparam int NBLK   = 8;
  localparam int BLK_W  = $clog2(NBLK);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, lock_dis = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [BLK_W-1:0]  wr_blk = '0;
  logic done = 1'b0, fail = 1'b0, blank = 1'b0;
  logic ready, lock_bit, start;
  logic [1:0] err, op;
  logic [BLK_W-1:0]  a_blk;
  logic [DATA_W-1:0] a_data;

  int checks = 0, errors = 0, starts = 0, stub_lat = 3;
  bit stub_fail = 0, stub_blank = 1;
  logic [1:0] m_err = 2'b00;
  bit m_unl [NBLK];

  always #4 clk = ~clk;

  flash_cmd_seq #(.DATA_W(DATA_W), .NBLK(NBLK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_blk_i(wr_blk), .lock_dis_i(lock_dis), .arr_done_i(done),
    .arr_fail_i(fail), .arr_blank_i(blank), .ready_o(ready), .err_o(err),
    .lock_bit_o(lock_bit), .arr_start_o(start), .arr_op_o(op),
    .arr_blk_o(a_blk), .arr_data_o(a_data)
  );

  // array stub and start counter
  initial forever begin
    @(negedge clk);
    if (start) begin
      starts++;
      repeat (stub_lat - 1) @(negedge clk);
      done = 1'b1; fail = stub_fail; blank = stub_blank;
      @(negedge clk);
      done = 1'b0; fail = 1'b0; blank = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [BLK_W-1:0] b);
    wr_en = 1'b1; wr_data = {8'hA5, d}; wr_blk = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_cmd(input string tag, input logic [7:0] code, input logic [7:0] conf,
                        input logic [BLK_W-1:0] b, input bit f, input bit bl);
    bit phase2 = 0, go = 0, rd = 0;
    int s0;
    stub_fail = f; stub_blank = bl;
    s0 = starts;
    case (code)
      8'hFF: ;
      8'h50: m_err = 2'b00;
      8'h40, 8'h20, 8'h25, 8'h77: if (m_err != 2'b00) m_err = 2'b11; else phase2 = 1;
      8'h71: phase2 = 1;
      default: m_err = 2'b11;
    endcase
    wr(code, b);
    if (phase2) begin
      if (code == 8'h40) begin
        if (!m_unl[b] && !lock_dis) m_err = 2'b01; else go = 1;
      end else if (conf == 8'hFF) ;
      else if (conf != 8'hD0) m_err = 2'b11;
      else case (code)
        8'h20: if (!m_unl[b] && !lock_dis) m_err = 2'b10; else go = 1;
        8'h71: rd = 1;
        default: go = 1;
      endcase
      wr(conf, b);
      if (rd) check({tag, " R12 lock"}, int'(lock_bit), int'(m_unl[b]));
    end
    if (go) begin
      check({tag, " R10 busy"}, int'(ready), 0);
      while (!ready) @(negedge clk);
      case (code)
        8'h20: if (f) m_err = 2'b10;
        8'h40: if (f) m_err = 2'b01;
        8'h25: if (!bl) m_err = 2'b10;
        8'h77: if (f) m_err = 2'b01; else m_unl[b] = 0;
        default: ;
      endcase
    end
    @(negedge clk);
    check({tag, " R10 start"}, starts - s0, int'(go));
    check({tag, " R2 err"}, int'(err), int'(m_err));
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < NBLK; i++) m_unl[i] = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 err", int'(err), 0);
    check("R1 start", int'(start), 0);
    check("R1 lockbit", int'(lock_bit), 1);
    for (int i = 0; i < NBLK; i++) do_cmd("R1 rdlock", 8'h71, 8'hD0, BLK_W'(i), 0, 1);

    do_cmd("R3 unknown", 8'h33, 8'hD0, 0, 0, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    do_cmd("R4 badconf", 8'h20, 8'h12, 1, 0, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    do_cmd("R5 cancel", 8'h20, 8'hFF, 1, 0, 1);
    do_cmd("R5 after", 8'h20, 8'hD0, 1, 0, 1);
    do_cmd("R6 erasefail", 8'h20, 8'hD0, 2, 1, 1);
    do_cmd("R11 reject", 8'h40, 8'h00, 2, 0, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    do_cmd("R7 notblank", 8'h25, 8'hD0, 4, 0, 0);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    do_cmd("R7 blank", 8'h25, 8'hD0, 4, 0, 1);
    do_cmd("R8 progfail", 8'h40, 8'h5A, 5, 1, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    do_cmd("R8 lockprog", 8'h77, 8'hD0, 3, 0, 1);
    do_cmd("R12 locked", 8'h71, 8'hD0, 3, 0, 1);
    do_cmd("R8 proglocked", 8'h40, 8'h11, 3, 0, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    do_cmd("R6 eraselocked", 8'h20, 8'hD0, 3, 0, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);
    lock_dis = 1'b1;
    do_cmd("R9 erase", 8'h20, 8'hD0, 3, 0, 1);
    do_cmd("R9 prog", 8'h40, 8'h22, 3, 0, 1);
    lock_dis = 1'b0;
    do_cmd("R8 lockfail", 8'h77, 8'hD0, 6, 1, 1);
    do_cmd("R2 clear", 8'h50, 8'hD0, 0, 0, 1);

    // R10: write during busy is ignored
    stub_lat = 6; stub_fail = 0;
    wr(8'h20, 0); wr(8'hD0, 0);
    check("R10 busy", int'(ready), 0);
    wr(8'h33, 0);
    check("R10 still busy", int'(ready), 0);
    while (!ready) @(negedge clk);
    @(negedge clk);
    check("R10 ignored", int'(err), 0);
    stub_lat = 3;

    for (int n = 0; n < 80; n++) begin
      logic [7:0] c, k;
      int sel = int'($urandom_range(0, 8));
      case (sel)
        0: c = 8'h40; 1: c = 8'h20; 2: c = 8'h25; 3: c = 8'h77;
        4: c = 8'h71; 5: c = 8'h50; 6: c = 8'h50; 7: c = 8'hFF;
        default: c = 8'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0: k = 8'hFF; 1: k = 8'($urandom); default: k = 8'hD0;
      endcase
      lock_dis = ($urandom_range(0, 3) == 0);
      do_cmd("R2 rand", c, k, BLK_W'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule